// File: doc/BRIEF.md
# Level-Interrupt GPIO Controller

This block is a register-mapped controller for twelve general-purpose pins. Software reaches it over a simple 32-bit bus made of a word select, a write strobe, write data and read data. It holds a driven value and a drive-enable bit for every pin. The pin inputs are resynchronised, and the result is available as a read-only word.

Each pin can also raise a level interrupt of programmable polarity. When a pin's level condition is seen, it sets a sticky status bit. That bit stays set until software writes a 1 to it. If the level is still present when software clears it, the bit sets again on the next cycle. A mask register selects which status bits may assert the single interrupt output. A free 32-bit word is stored and driven out to steer the external pin multiplexer.

Top module: `gpio_lvl_ctrl`

## Requirements
- R1: After a synchronous reset, every register reads zero and `pin_out`, `pin_oe`, `mux_word` and `irq_out` are all zero.
- R2: Writing word 0 (byte 0x00) sets the driven value `pin_out`, and writing word 1 (0x04) sets the drive enables `pin_oe`. Both registers read back their value in bits 11:0, and bits 31:12 read zero.
- R3: Word 2 (0x08) reads `pin_in` after a two-flop synchronizer. A change appears after two clock edges and not after one. Writes to word 2 have no effect.
- R4: Polarity for pin n sits at bit 4*(n mod 8) of word 4 (0x10) for pins 0–7, and of word 6 (0x18) for pins 8–11. A value of 0 means active-high and 1 means active-low. All other bits of these words read zero.
- R5: The status bits sit at word 3 (0x0C), bit n for pin n. A status bit sets once its synchronized level condition is seen, and it stays set after the condition goes away.
- R6: Writing a 1 to a status bit clears it when its condition is inactive. Writing 0 leaves the bit unchanged.
- R7: If a clear and an active condition meet in the same cycle, the status bit stays set.
- R8: The enable bits sit at word 5 (0x14), where 1 unmasks a pin. `irq_out` is high exactly when a status bit and its enable bit are both set. A status bit records its condition even while masked.
- R9: Word 7 (0x1C) is a full 32-bit read/write word that drives `mux_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 3 | Word select (byte offset / 4) |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected word |
| pin_in | input | 12 | Asynchronous pin levels |
| pin_out | output | 12 | Driven pin values |
| pin_oe | output | 12 | Per-pin drive enables |
| mux_word | output | 32 | Pin-multiplexer control word |
| irq_out | output | 1 | Combined interrupt request |

## Verification
Several properties hold on every cycle for every pin. A set status bit holds unless a clear reaches it. An active condition always leaves its bit set on the next cycle. A clear with no condition drops the bit. With all enables at zero, the interrupt stays low. The mux and output writes land on their ports one cycle after the write. Other behaviour can only be shown by the bench's scenarios: the polarity bit positions spread across two words, the two-edge synchronizer latency, read-only inputs, and masking while status is still recorded.

// File: rtl/gpio_lvl_pkg.sv
package gpio_lvl_pkg;

    typedef enum logic [2:0] {
        SEL_OUT     = 3'd0,
        SEL_OE      = 3'd1,
        SEL_IN      = 3'd2,
        SEL_STAT    = 3'd3,
        SEL_POL_LO  = 3'd4,
        SEL_EN      = 3'd5,
        SEL_POL_HI  = 3'd6,
        SEL_MUX     = 3'd7
    } reg_sel_e;

    localparam int PINS_PER_POL_WORD = 8;
    localparam int POL_STRIDE        = 4;

    // bit index of a pin's polarity flag inside its type word
    function automatic int pol_bit(input int pin);
        return POL_STRIDE * (pin % PINS_PER_POL_WORD);
    endfunction

    // which type word holds the pin's polarity flag
    function automatic reg_sel_e pol_word(input int pin);
        return (pin < PINS_PER_POL_WORD) ? SEL_POL_LO : SEL_POL_HI;
    endfunction

endpackage

// File: rtl/gpio_lvl_sync.sv
module gpio_lvl_sync #(
    parameter int WIDTH  = 12,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= '0;
        end else begin
            chain[0] <= d_async;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/gpio_lvl_status.sv
module gpio_lvl_status #(
    parameter int N_PINS = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_PINS-1:0] level_sync,
    input  logic [N_PINS-1:0] active_low,
    input  logic [N_PINS-1:0] clr_mask,
    input  logic [N_PINS-1:0] enable,
    output logic [N_PINS-1:0] status,
    output logic              irq
);
    logic [N_PINS-1:0] cond;
    logic [N_PINS-1:0] status_q;

    assign cond = level_sync ^ active_low;

    // a fresh condition overrides a clear issued in the same cycle
    always_ff @(posedge clk) begin
        if (rst) status_q <= '0;
        else     status_q <= (status_q & ~clr_mask) | cond;
    end

    assign status = status_q;
    assign irq    = |(status_q & enable);

    for (genvar i = 0; i < N_PINS; i++) begin : g_chk
        p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
            (status_q[i] && !clr_mask[i]) |=> status_q[i]);
        p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
            cond[i] |=> status_q[i]);
        p_clear_r6: assert property (@(posedge clk) disable iff (rst)
            (clr_mask[i] && !cond[i]) |=> !status_q[i]);
    end
endmodule

// File: rtl/gpio_lvl_ctrl.sv
module gpio_lvl_ctrl
    import gpio_lvl_pkg::*;
#(
    parameter int N_PINS = 12,
    parameter int DATA_W = 32,
    parameter int SEL_W  = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  bus_sel,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N_PINS-1:0] pin_in,
    output logic [N_PINS-1:0] pin_out,
    output logic [N_PINS-1:0] pin_oe,
    output logic [DATA_W-1:0] mux_word,
    output logic              irq_out
);
    reg_sel_e          sel;
    logic [N_PINS-1:0] out_q, oe_q, en_q, pol_q;
    logic [DATA_W-1:0] mux_q;
    logic [N_PINS-1:0] in_sync, status, clr_mask;
    logic [N_PINS-1:0] pol_hit, pol_val;

    assign sel = reg_sel_e'(bus_sel);

    for (genvar k = 0; k < N_PINS; k++) begin : g_pol
        assign pol_hit[k] = bus_we && (sel == pol_word(k));
        assign pol_val[k] = bus_wdata[pol_bit(k)];
    end

    assign clr_mask = (bus_we && sel == SEL_STAT) ? bus_wdata[N_PINS-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
            oe_q  <= '0;
            en_q  <= '0;
            mux_q <= '0;
        end else if (bus_we) begin
            case (sel)
                SEL_OUT: out_q <= bus_wdata[N_PINS-1:0];
                SEL_OE:  oe_q  <= bus_wdata[N_PINS-1:0];
                SEL_EN:  en_q  <= bus_wdata[N_PINS-1:0];
                SEL_MUX: mux_q <= bus_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pol_q <= '0;
        else begin
            for (int k = 0; k < N_PINS; k++)
                if (pol_hit[k]) pol_q[k] <= pol_val[k];
        end
    end

    gpio_lvl_sync #(.WIDTH(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (pin_in),
        .q_sync  (in_sync)
    );

    gpio_lvl_status #(.N_PINS(N_PINS)) u_status (
        .clk        (clk),
        .rst        (rst),
        .level_sync (in_sync),
        .active_low (pol_q),
        .clr_mask   (clr_mask),
        .enable     (en_q),
        .status     (status),
        .irq        (irq_out)
    );

    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_OUT:  bus_rdata[N_PINS-1:0] = out_q;
            SEL_OE:   bus_rdata[N_PINS-1:0] = oe_q;
            SEL_IN:   bus_rdata[N_PINS-1:0] = in_sync;
            SEL_STAT: bus_rdata[N_PINS-1:0] = status;
            SEL_EN:   bus_rdata[N_PINS-1:0] = en_q;
            SEL_MUX:  bus_rdata = mux_q;
            SEL_POL_LO, SEL_POL_HI: begin
                for (int k = 0; k < N_PINS; k++)
                    if (pol_word(k) == sel) bus_rdata[pol_bit(k)] = pol_q[k];
            end
            default: ;
        endcase
    end

    assign pin_out  = out_q;
    assign pin_oe   = oe_q;
    assign mux_word = mux_q;

    p_mux_write_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_we && sel == SEL_MUX) |=> (mux_word == $past(bus_wdata)));
    p_out_write_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_we && sel == SEL_OUT) |=> (pin_out == $past(bus_wdata[N_PINS-1:0])));
    p_masked_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (en_q == '0) |-> !irq_out);
endmodule

// File: tb/gpio_lvl_ctrl_test.sv
`timescale 1ns/1ps
module gpio_lvl_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  bus_sel = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [11:0] pin_in = '0;
    logic [11:0] pin_out, pin_oe;
    logic [31:0] mux_word;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gpio_lvl_ctrl uut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .mux_word(mux_word), .irq_out(irq_out)
    );

    typedef struct packed {
        logic [2:0]  sel;
        logic [31:0] wr;
        logic [31:0] exp;
    } vec_t;

    // register write / read-back table (R2, R4, R8, R9)
    localparam vec_t TBL [0:7] = '{
        '{3'd0, 32'hFFFF_FFFF, 32'h0000_0FFF},
        '{3'd0, 32'h1234_55A5, 32'h0000_05A5},
        '{3'd1, 32'hFFFF_FA5A, 32'h0000_0A5A},
        '{3'd5, 32'hF000_0123, 32'h0000_0123},
        '{3'd4, 32'hFFFF_FFFF, 32'h1111_1111},
        '{3'd6, 32'hFFFF_FFFF, 32'h0000_1111},
        '{3'd7, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
        '{3'd5, 32'h0000_0000, 32'h0000_0000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [31:0] d);
        @(negedge clk);
        bus_sel = s; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] s, output logic [31:0] d);
        bus_sel = s;
        #1 d = bus_rdata;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #100000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        wait_cyc(3);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        for (int s = 0; s < 8; s++) begin
            rd(s[2:0], r);
            check("R1 register reset", r, 32'h0);
        end
        check("R1 pin_out", {20'h0, pin_out}, 32'h0);
        check("R1 pin_oe", {20'h0, pin_oe}, 32'h0);
        check("R1 mux_word", mux_word, 32'h0);
        check("R1 irq_out", {31'h0, irq_out}, 32'h0);

        // table walk
        for (int i = 0; i < 8; i++) begin
            wr(TBL[i].sel, TBL[i].wr);
            rd(TBL[i].sel, r);
            check("R2/R4/R8/R9 readback", r, TBL[i].exp);
        end
        check("R2 pin_out port", {20'h0, pin_out}, 32'h5A5);
        check("R2 pin_oe port", {20'h0, pin_oe}, 32'hA5A);
        check("R9 mux_word port", mux_word, 32'hDEAD_BEEF);

        // all pins active-low with inputs low: every status bit sets (R4)
        wait_cyc(4);
        rd(3'd3, r);
        check("R4 active-low sets all", r, 32'hFFF);
        wr(3'd4, 32'h0); wr(3'd6, 32'h0);
        wait_cyc(3);
        wr(3'd3, 32'hFFF);
        rd(3'd3, r);
        check("R6 clear all", r, 32'h0);

        // R3: synchronizer latency and read-only
        @(negedge clk);
        pin_in = 12'hABC;
        bus_sel = 3'd2;
        @(negedge clk);
        rd(3'd2, r);
        check("R3 after one edge", r, 32'h0);
        @(negedge clk);
        rd(3'd2, r);
        check("R3 after two edges", r, 32'hABC);
        wr(3'd2, 32'hFFF);
        rd(3'd2, r);
        check("R3 write ignored", r, 32'hABC);

        // R8: recorded while masked, enable gates irq
        wait_cyc(2);
        rd(3'd3, r);
        check("R8 status recorded while masked", r, 32'hABC);
        check("R8 irq masked", {31'h0, irq_out}, 32'h0);
        wr(3'd5, 32'h004);
        check("R8 irq unmasked", {31'h0, irq_out}, 32'h1);
        wr(3'd5, 32'h001);
        check("R8 irq enable on idle pin", {31'h0, irq_out}, 32'h0);

        // R7: clear while level still active
        wr(3'd3, 32'hFFF);
        rd(3'd3, r);
        check("R7 set wins over clear", r, 32'hABC);

        // R5: sticky after level removed
        @(negedge clk);
        pin_in = 12'h000;
        wait_cyc(4);
        rd(3'd3, r);
        check("R5 sticky", r, 32'hABC);

        // R6: write 0 no effect, write 1 clears
        wr(3'd3, 32'h000);
        rd(3'd3, r);
        check("R6 write zero", r, 32'hABC);
        wr(3'd3, 32'h008);
        rd(3'd3, r);
        check("R6 single clear", r, 32'hAB4);
        wr(3'd3, 32'hFFF);
        rd(3'd3, r);
        check("R6 clear remaining", r, 32'h0);

        // R4: pin 9 via upper word bit 4, pin 3 via lower word bit 12
        wr(3'd6, 32'h0000_0010);
        wr(3'd4, 32'h0000_1000);
        wait_cyc(4);
        rd(3'd3, r);
        check("R4 per-pin polarity", r, 32'h208);
        @(negedge clk);
        pin_in = 12'h208;
        wait_cyc(4);
        wr(3'd3, 32'hFFF);
        rd(3'd3, r);
        check("R4 active-low released", r, 32'h0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule